// File: doc/BRIEF.md
# Serial Binary Adder with Registered Carry Loop

This block adds two unsigned operands of a configurable length, one bit pair per clock cycle, starting with the least significant bit. It produces one sum bit per accepted pair, in the same order, one cycle after the pair arrives. The carry between bit positions is kept in a single register that feeds back into the full adder.

A start flag on the first pair of an operand forces the incoming carry to zero for that pair, so a new addition never inherits the carry of the previous one. Once the final operand pair has been accepted, the block spends one more cycle presenting the stored carry as the top sum bit and flags it as the last bit. A complete addition of N-bit operands therefore occupies N+1 cycles. While that extra cycle is in progress, input is refused.

Input pairs may arrive with idle gaps inside an operand. The carry and the bit position are held across such gaps.

Top module: `serial_adder`

## Requirements
- R1: While reset is asserted and after its release with no input, sumValid, sumBit and sumLast are all 0.
- R2: A pair accepted with inStart=1 is added with an incoming carry of 0, whatever carry an earlier addition left behind.
- R3: For every accepted pair at bit position i (0 to WIDTH-1, LSB first), the next cycle shows sumValid=1, sumLast=0 and sumBit = x ^ y ^ c, where c is the carry stored from position i-1 (0 at position 0).
- R4: The cycle after the pair at position WIDTH-1 is accepted, sumBit equals the final carry (sum bit WIDTH), with sumValid=1 and sumLast=1. sumLast is 1 in no other cycle.
- R5: A cycle with inValid=0 inside an operand produces no valid output and leaves the stored carry and bit position unchanged.
- R6: Input presented during the carry-out cycle is ignored, even with inStart=1. A pair with inValid=1 and inStart=0 while no operand is in progress is also ignored. Neither produces output, and neither disturbs the following addition.
- R7: inStart=1 with inValid=1 in the middle of an operand abandons that operand and starts a new one at position 0.
- R8: Additions can follow one another with no idle cycle. Each addition takes WIDTH+1 cycles, so a new start can be accepted in the cycle right after the previous carry-out cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operand bit pair is present |
| inStart | input | 1 | Marks the pair at bit position 0 |
| inX | input | 1 | Bit of the first operand |
| inY | input | 1 | Bit of the second operand |
| sumValid | output | 1 | sumBit carries a result bit |
| sumBit | output | 1 | Sum bit, LSB first, final carry last |
| sumLast | output | 1 | The current sum bit is the final carry |

## Verification
The bench builds the adder with WIDTH=8. At that size an all-ones pair drives the carry through every position and out as sum bit 8, and it is cheap to run long chains of back-to-back additions. The directed cases use the middle bit position for an idle gap and the third position for an abandoned operand. A run of additions that alternates between a carry-out of one and a pair of zeros shows whether the start flag really discards the leftover carry.

// File: rtl/serad_pkg.sv
package serad_pkg;

  // Per-cycle commands from the frame control to the datapath.
  typedef struct packed {
    logic clearCarry;  // accepted pair is bit 0: incoming carry forced to 0
    logic sampleBit;   // an operand pair is accepted this cycle
    logic emitCarry;   // present stored carry as the top sum bit
  } serStrobe_t;

endpackage

// File: rtl/serad_fa.sv
module serad_fa (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic genTerm,
  output logic propTerm,
  output logic cout
);

  logic halfSum;

  always_comb begin
    halfSum  = a ^ b;
    sum      = halfSum ^ cin;
    genTerm  = a & b;
    propTerm = cin & halfSum;
    // The two terms are exclusive, so a plain merge forms the carry.
    cout     = genTerm | propTerm;
  end

endmodule

// File: rtl/serad_ctrl.sv
module serad_ctrl
  import serad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  output serStrobe_t strobe
);

  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

  logic             busy;
  logic             emitPending;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] curIdx;
  logic             accept;
  logic             lastBit;

  always_comb begin
    accept  = inValid && !emitPending && (inStart || busy);
    curIdx  = inStart ? '0 : bitIdx;
    lastBit = accept && (curIdx == LAST_IDX);

    strobe.clearCarry = accept && inStart;
    strobe.sampleBit  = accept;
    strobe.emitCarry  = emitPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      emitPending <= 1'b0;
      bitIdx      <= '0;
    end else begin
      emitPending <= lastBit;
      if (accept) begin
        if (lastBit) begin
          busy   <= 1'b0;
          bitIdx <= '0;
        end else begin
          busy   <= 1'b1;
          bitIdx <= IDX_W'(curIdx + 1'b1);
        end
      end
    end
  end

  // R4: accepting the top pair schedules the carry-out cycle next.
  p_emit_after_top_r4 : assert property (@(posedge clk) disable iff (!rstN)
    lastBit |=> strobe.emitCarry);

  // R4: the carry-out cycle lasts a single cycle.
  p_emit_single_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitCarry |=> !strobe.emitCarry);

  // R3: the bit position never runs past the operand length.
  p_idx_in_range_r3 : assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_IDX);

  // R6: once no operand is in progress, the position is back at 0.
  p_idle_idx_zero_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (bitIdx == '0));

endmodule

// File: rtl/serad_datapath.sv
module serad_datapath
  import serad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  serStrobe_t strobe,
  input  logic       inX,
  input  logic       inY,
  output logic       sumValid,
  output logic       sumBit,
  output logic       sumLast
);

  logic carryReg;
  logic carryIn;
  logic rawSum;
  logic genTerm;
  logic propTerm;
  logic nextCarry;

  always_comb carryIn = strobe.clearCarry ? 1'b0 : carryReg;

  serad_fa u_fa (
    .a        (inX),
    .b        (inY),
    .cin      (carryIn),
    .sum      (rawSum),
    .genTerm  (genTerm),
    .propTerm (propTerm),
    .cout     (nextCarry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryReg <= 1'b0;
      sumValid <= 1'b0;
      sumBit   <= 1'b0;
      sumLast  <= 1'b0;
    end else if (strobe.sampleBit) begin
      carryReg <= nextCarry;
      sumValid <= 1'b1;
      sumBit   <= rawSum;
      sumLast  <= 1'b0;
    end else if (strobe.emitCarry) begin
      sumValid <= 1'b1;
      sumBit   <= carryReg;
      sumLast  <= 1'b1;
    end else begin
      sumValid <= 1'b0;
      sumBit   <= 1'b0;
      sumLast  <= 1'b0;
    end
  end

  // R2: the first pair of an operand is summed with no incoming carry.
  p_start_clears_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleBit && strobe.clearCarry) |=> (sumBit == ($past(inX) ^ $past(inY))));

  // R5: the stored carry moves only when a pair is accepted.
  p_carry_hold_r5 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleBit |=> $stable(carryReg));

  // R4: the carry-out cycle shows the carry stored before it.
  p_emit_value_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitCarry |=> (sumBit == $past(carryReg)) && sumLast && sumValid);

  // R4: the last flag never appears without a valid bit.
  p_last_valid_r4 : assert property (@(posedge clk) disable iff (!rstN)
    sumLast |-> sumValid);

endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import serad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inStart,
  input  logic inX,
  input  logic inY,
  output logic sumValid,
  output logic sumBit,
  output logic sumLast
);

  serStrobe_t strobe;

  serad_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .strobe  (strobe)
  );

  serad_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inX      (inX),
    .inY      (inY),
    .sumValid (sumValid),
    .sumBit   (sumBit),
    .sumLast  (sumLast)
  );

endmodule

// File: tb/sim_serial_adder.sv
`timescale 1ns/1ps
module sim_serial_adder;

  localparam int W = 8;
  localparam int NVEC = 10;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    16'hFF_FF, 16'h00_00, 16'h01_01, 16'h80_80, 16'h5A_A5,
    16'h7F_01, 16'hFF_FF, 16'h00_00, 16'hAA_55, 16'hFE_03
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inStart = 1'b0, inX = 1'b0, inY = 1'b0;
  logic sumValid, sumBit, sumLast;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_adder #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inX(inX), .inY(inY), .sumValid(sumValid), .sumBit(sumBit), .sumLast(sumLast)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Entered at a negedge; drives one operand and collects its WIDTH+1 sum
  // bits; returns at the negedge where the next operand may start at once.
  task automatic runFrame(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit junkEmit, input bit gap, input string tag);
    logic [W:0] got;
    logic [W:0] exp;
    bit framingOk;
    got = '0;
    framingOk = 1'b1;
    exp = {1'b0, a} + {1'b0, b};
    for (int i = 0; i < W; i++) begin
      if (i > 0) begin
        @(negedge clk);
        framingOk &= sumValid && !sumLast;
        got[i-1] = sumBit;
      end
      if (gap && i == W/2) begin
        inValid = 1'b0; inStart = 1'b0; inX = 1'b1; inY = 1'b1;
        @(negedge clk);
        check(!sumValid, "R5", "output valid during gap", sumValid, 0);
      end
      inValid = 1'b1; inStart = (i == 0); inX = a[i]; inY = b[i];
    end
    @(negedge clk);
    framingOk &= sumValid && !sumLast;
    got[W-1] = sumBit;
    inValid = junkEmit; inStart = junkEmit; inX = 1'b1; inY = 1'b1;
    @(negedge clk);
    framingOk &= sumValid && sumLast;
    got[W] = sumBit;
    inValid = 1'b0; inStart = 1'b0; inX = 1'b0; inY = 1'b0;
    check(got == exp, tag, "reassembled sum", got, exp);
    check(framingOk, "R4", "valid/last framing", framingOk, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sumValid && !sumLast && !sumBit, "R1", "outputs in reset",
          {sumValid, sumLast, sumBit}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sumValid && !sumLast && !sumBit, "R1", "outputs after reset",
          {sumValid, sumLast, sumBit}, 0);

    // R3 / R8 / R2: back-to-back table; all-ones followed by zeros shows
    // that a start discards the carry left by the previous addition.
    for (int v = 0; v < NVEC; v++)
      runFrame(VEC[v][2*W-1:W], VEC[v][W-1:0], 1'b0, 1'b0,
               (v == 1 || v == 7) ? "R2" : "R8");

    // R3: random operands, back to back.
    for (int r = 0; r < 6; r++)
      runFrame(W'($urandom), W'($urandom), 1'b0, 1'b0, "R3");

    // R6: pairs without a start while idle are ignored.
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      inValid = 1'b1; inStart = 1'b0; inX = 1'b1; inY = 1'b1;
      @(negedge clk);
      check(!sumValid, "R6", "output from pair without start", sumValid, 0);
    end
    inValid = 1'b0;
    @(negedge clk);
    check(!sumValid, "R6", "output after ignored pairs", sumValid, 0);

    // R6: start presented during the carry-out cycle is ignored.
    runFrame(8'hFF, 8'h01, 1'b1, 1'b0, "R6");
    runFrame(8'h00, 8'h00, 1'b0, 1'b0, "R6");

    // R5: idle gap in the middle of an operand.
    runFrame(8'hB7, 8'h6D, 1'b0, 1'b1, "R5");

    // R7: abandon an operand after three bits and restart.
    for (int k = 0; k < 3; k++) begin
      inValid = 1'b1; inStart = (k == 0); inX = 1'b1; inY = 1'b1;
      @(negedge clk);
    end
    runFrame(8'h0F, 8'h01, 1'b0, 1'b0, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule